// File: doc/BRIEF.md
# Bus Event Record Queue

This block collects pending bus events for a host processor and hands them out one at a time in arrival order. Two producers feed a single 16-record queue. One is a direct error-event port, which carries a function identifier, a function handle, a 32-bit qualifier, a 64-bit faulting address and a 16-bit event code. The other is a built-in hot-plug sequencer, which turns plug and unplug requests into fixed, ordered pairs of availability events. Every record that enters the queue raises a one-cycle notification toward the host.

The host polls `not_empty` and pulses `pop_req`. One cycle later `pop_done` rises with a status bit, a 2-bit record-type code and a 176-bit record. The record is laid out big-endian, with the first field in the top bits. A push into a full queue is discarded and latches a sticky overflow flag.

The sequencer has five named states:

- **SEQ_IDLE** waits for a request.
- **SEQ_PLUG_STBY** emits reserved-to-standby.
- **SEQ_PLUG_CFG** emits standby-to-configured.
- **SEQ_UNPLUG_DECFG** emits configured-to-standby/reserved.
- **SEQ_UNPLUG_RSV** emits standby-to-reserved.

The transitions are:

- SEQ_IDLE goes to SEQ_PLUG_STBY on a plug request while the system is live.
- SEQ_IDLE goes to SEQ_UNPLUG_DECFG on an unplug of a configured function.
- SEQ_IDLE goes to SEQ_UNPLUG_RSV on an unplug of an unconfigured function.
- SEQ_PLUG_STBY goes to SEQ_PLUG_CFG, and SEQ_PLUG_CFG goes to SEQ_IDLE.
- SEQ_UNPLUG_DECFG goes to SEQ_UNPLUG_RSV, and SEQ_UNPLUG_RSV goes to SEQ_IDLE.

Each emitting state advances only in a cycle without an error push.

Top module: `bus_evt_queue`

## Requirements
- R1: Records are popped strictly oldest first, whichever producer pushed them.
- R2: `pop_done` is high in the cycle after `pop_req`. `pop_status` is 0 when a record was delivered and 1 when the queue was empty; on an empty pop, `pop_type` is 0 and `pop_rec` is all zero.
- R3: An error record pops with `pop_type` = 1 and `pop_rec` = {fid[31:0], fh[31:0], qualifier[31:0], faddr[63:0], code[15:0]}, most significant field in bits 175 down.
- R4: An availability record pops with `pop_type` = 2 and `pop_rec` = {fid[31:0], fh[31:0], code[15:0], 96 zero bits}.
- R5: `notify` is high for exactly the one cycle after each accepted push; a dropped push raises no notification.
- R6: A plug request with `plug_live` = 1 latches fid/handle into the slot and pushes code 0x0302 (reserved-to-standby) then 0x0301 (standby-to-configured). With `plug_live` = 0 it only latches the slot and pushes nothing.
- R7: An unplug with `unplug_cfg` = 1 pushes 0x0304 then 0x0308; with `unplug_cfg` = 0 it pushes only 0x0308. Both events carry the slot's fid/handle, and afterwards the slot fid and handle read zero.
- R8: The queue holds 16 records. A push while 16 are held is discarded and sets `overflow`, which stays set until reset.
- R9: An error push has priority over a sequencer event in the same cycle; the sequencer holds its state and emits one cycle later. Plug and unplug requests are ignored while `seq_busy` is high.
- R10: `not_empty` is high exactly when at least one record is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_push | input | 1 | Push one error record this cycle |
| err_fid | input | 32 | Error record function identifier |
| err_fh | input | 32 | Error record function handle |
| err_qual | input | 32 | Error qualifier word |
| err_faddr | input | 64 | Faulting address |
| err_code | input | 16 | Error event code |
| plug_req | input | 1 | Plug request pulse |
| plug_live | input | 1 | System running at plug time |
| plug_fid | input | 32 | Function identifier of plugged function |
| plug_fh | input | 32 | Function handle of plugged function |
| unplug_req | input | 1 | Unplug request pulse |
| unplug_cfg | input | 1 | Function is configured at unplug time |
| slot_fid | output | 32 | Latched slot function identifier |
| slot_fh | output | 32 | Latched slot function handle |
| seq_busy | output | 1 | Sequencer is emitting events |
| pop_req | input | 1 | Host pop request |
| pop_done | output | 1 | Pop result valid |
| pop_status | output | 1 | 0 delivered, 1 queue was empty |
| pop_type | output | 2 | Record type code (1 error, 2 availability, 0 none) |
| pop_rec | output | 176 | Big-endian packed record |
| not_empty | output | 1 | Queue holds a record |
| overflow | output | 1 | Sticky dropped-push flag |
| notify | output | 1 | Notification pulse per accepted push |

## Verification
The two functions that can meet in one cycle are an error push and a sequencer emission. The bench provokes this by raising `err_push`, together with a stray unplug request, in the first cycle that the sequencer spends in SEQ_PLUG_STBY. It then pops the queue and requires the order error, 0x0302, 0x0301, followed by an empty pop. The slot must still show the plugged identifier, which proves that the unplug was ignored.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int FID_W  = 32;
    localparam int FH_W   = 32;
    localparam int QUAL_W = 32;
    localparam int ADDR_W = 64;
    localparam int CODE_W = 16;
    localparam int REC_W  = FID_W + FH_W + QUAL_W + ADDR_W + CODE_W;
    localparam int PAD_W  = REC_W - FID_W - FH_W - CODE_W;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_ERR   = 2'd1,
        KIND_AVAIL = 2'd2
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e            kind;
        logic [FID_W-1:0]    fid;
        logic [FH_W-1:0]     fh;
        logic [QUAL_W-1:0]   qual;
        logic [ADDR_W-1:0]   faddr;
        logic [CODE_W-1:0]   code;
    } ev_rec_t;

    localparam logic [CODE_W-1:0] CODE_RSV_TO_STBY    = 16'h0302;
    localparam logic [CODE_W-1:0] CODE_STBY_TO_CFG    = 16'h0301;
    localparam logic [CODE_W-1:0] CODE_CFG_TO_STBYRSV = 16'h0304;
    localparam logic [CODE_W-1:0] CODE_STBY_TO_RSV    = 16'h0308;

    typedef enum logic [2:0] {
        SEQ_IDLE         = 3'd0,
        SEQ_PLUG_STBY    = 3'd1,
        SEQ_PLUG_CFG     = 3'd2,
        SEQ_UNPLUG_DECFG = 3'd3,
        SEQ_UNPLUG_RSV   = 3'd4
    } seq_state_e;
endpackage

// File: rtl/evq_fifo.sv
module evq_fifo
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  ev_rec_t                          push_rec,
    input  logic                             pop,
    output logic                             pop_done,
    output logic                             pop_status,
    output ev_rec_t                          pop_out,
    output logic                             not_empty,
    output logic                             overflow,
    output logic                             notify,
    output logic                             push_ok,
    output logic [$clog2(DEPTH+1)-1:0]       count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    ev_rec_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, deq;

    assign full      = (cnt_q == FULL_CNT);
    assign push_ok   = push && !full;
    assign deq       = pop && (cnt_q != '0);
    assign not_empty = (cnt_q != '0);
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q       <= '0;
            rd_q       <= '0;
            cnt_q      <= '0;
            notify     <= 1'b0;
            overflow   <= 1'b0;
            pop_done   <= 1'b0;
            pop_status <= 1'b0;
            pop_out    <= '0;
        end else begin
            if (push_ok) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            if (deq)     rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            unique case ({push_ok, deq})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            notify   <= push_ok;
            overflow <= overflow | (push && full);
            pop_done <= pop;
            if (pop) begin
                pop_status <= !deq;
                pop_out    <= deq ? mem[rd_q] : '0;
            end
        end
    end
endmodule

// File: rtl/evq_seq.sv
module evq_seq
    import evq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plug_req,
    input  logic              plug_live,
    input  logic [FID_W-1:0]  plug_fid,
    input  logic [FH_W-1:0]   plug_fh,
    input  logic              unplug_req,
    input  logic              unplug_cfg,
    input  logic              hold,
    output logic              ev_valid,
    output ev_rec_t           ev_rec,
    output logic [FID_W-1:0]  slot_fid,
    output logic [FH_W-1:0]   slot_fh,
    output logic              busy,
    output seq_state_e        state
);
    seq_state_e        state_q, state_d;
    logic [CODE_W-1:0] code;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (plug_req) begin
                    if (plug_live) state_d = SEQ_PLUG_STBY;
                end else if (unplug_req) begin
                    state_d = unplug_cfg ? SEQ_UNPLUG_DECFG : SEQ_UNPLUG_RSV;
                end
            end
            SEQ_PLUG_STBY:    if (!hold) state_d = SEQ_PLUG_CFG;
            SEQ_PLUG_CFG:     if (!hold) state_d = SEQ_IDLE;
            SEQ_UNPLUG_DECFG: if (!hold) state_d = SEQ_UNPLUG_RSV;
            SEQ_UNPLUG_RSV:   if (!hold) state_d = SEQ_IDLE;
            default:          state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        ev_valid = 1'b0;
        code     = '0;
        unique case (state_q)
            SEQ_PLUG_STBY:    begin ev_valid = 1'b1; code = CODE_RSV_TO_STBY;    end
            SEQ_PLUG_CFG:     begin ev_valid = 1'b1; code = CODE_STBY_TO_CFG;    end
            SEQ_UNPLUG_DECFG: begin ev_valid = 1'b1; code = CODE_CFG_TO_STBYRSV; end
            SEQ_UNPLUG_RSV:   begin ev_valid = 1'b1; code = CODE_STBY_TO_RSV;    end
            default:          begin ev_valid = 1'b0; code = '0;                  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_fid <= '0;
            slot_fh  <= '0;
        end else if (state_q == SEQ_IDLE && plug_req) begin
            slot_fid <= plug_fid;
            slot_fh  <= plug_fh;
        end else if (state_q == SEQ_UNPLUG_RSV && !hold) begin
            slot_fid <= '0;
            slot_fh  <= '0;
        end
    end

    always_comb begin
        ev_rec       = '0;
        ev_rec.kind  = KIND_AVAIL;
        ev_rec.fid   = slot_fid;
        ev_rec.fh    = slot_fh;
        ev_rec.code  = code;
    end

    assign busy  = (state_q != SEQ_IDLE);
    assign state = state_q;
endmodule

// File: rtl/evq_pack.sv
module evq_pack
    import evq_pkg::*;
(
    input  ev_rec_t          rec,
    output logic [1:0]       kind,
    output logic [REC_W-1:0] packed_rec
);
    always_comb begin
        kind = rec.kind;
        unique case (rec.kind)
            KIND_ERR:   packed_rec = {rec.fid, rec.fh, rec.qual, rec.faddr, rec.code};
            KIND_AVAIL: packed_rec = {rec.fid, rec.fh, rec.code, {PAD_W{1'b0}}};
            default:    packed_rec = '0;
        endcase
    end
endmodule

// File: rtl/bus_evt_queue.sv
module bus_evt_queue
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         err_push,
    input  logic [31:0]  err_fid,
    input  logic [31:0]  err_fh,
    input  logic [31:0]  err_qual,
    input  logic [63:0]  err_faddr,
    input  logic [15:0]  err_code,
    input  logic         plug_req,
    input  logic         plug_live,
    input  logic [31:0]  plug_fid,
    input  logic [31:0]  plug_fh,
    input  logic         unplug_req,
    input  logic         unplug_cfg,
    output logic [31:0]  slot_fid,
    output logic [31:0]  slot_fh,
    output logic         seq_busy,
    input  logic         pop_req,
    output logic         pop_done,
    output logic         pop_status,
    output logic [1:0]   pop_type,
    output logic [175:0] pop_rec,
    output logic         not_empty,
    output logic         overflow,
    output logic         notify
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ev_rec_t          err_rec, seq_rec, push_rec, head_rec;
    logic             seq_valid, push_any, push_ok;
    seq_state_e       seq_state;
    logic [CNT_W-1:0] fifo_count;

    always_comb begin
        err_rec       = '0;
        err_rec.kind  = KIND_ERR;
        err_rec.fid   = err_fid;
        err_rec.fh    = err_fh;
        err_rec.qual  = err_qual;
        err_rec.faddr = err_faddr;
        err_rec.code  = err_code;
    end

    evq_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .plug_req   (plug_req),
        .plug_live  (plug_live),
        .plug_fid   (plug_fid),
        .plug_fh    (plug_fh),
        .unplug_req (unplug_req),
        .unplug_cfg (unplug_cfg),
        .hold       (err_push),
        .ev_valid   (seq_valid),
        .ev_rec     (seq_rec),
        .slot_fid   (slot_fid),
        .slot_fh    (slot_fh),
        .busy       (seq_busy),
        .state      (seq_state)
    );

    assign push_any = err_push | seq_valid;
    assign push_rec = err_push ? err_rec : seq_rec;

    evq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_any),
        .push_rec   (push_rec),
        .pop        (pop_req),
        .pop_done   (pop_done),
        .pop_status (pop_status),
        .pop_out    (head_rec),
        .not_empty  (not_empty),
        .overflow   (overflow),
        .notify     (notify),
        .push_ok    (push_ok),
        .count      (fifo_count)
    );

    evq_pack u_pack (
        .rec        (head_rec),
        .kind       (pop_type),
        .packed_rec (pop_rec)
    );
endmodule

// File: rtl/evq_chk.sv
module evq_chk
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       err_push,
    input logic                       pop_req,
    input logic                       pop_done,
    input logic                       pop_status,
    input logic [1:0]                 pop_type,
    input logic                       not_empty,
    input logic                       overflow,
    input logic                       notify,
    input logic                       push_ok,
    input seq_state_e                 seq_state,
    input logic [31:0]                slot_fid,
    input logic [31:0]                slot_fh,
    input logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    AST_POP_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> pop_done); // R2
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !not_empty) |=> (pop_status && pop_type == 2'd0)); // R2
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_done && !pop_status) |-> (pop_type == 2'd1 || pop_type == 2'd2)); // R3
    AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> notify); // R5
    AST_PLUG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_PLUG_STBY && !err_push) |=> (seq_state == SEQ_PLUG_CFG)); // R6
    AST_UNPLUG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_UNPLUG_RSV && !err_push) |=> (slot_fid == 32'd0 && slot_fh == 32'd0)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow) |-> overflow); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R8
    AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_push && seq_state != SEQ_IDLE) |=> $stable(seq_state)); // R9
    AST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> not_empty); // R10
endmodule

bind bus_evt_queue evq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_push   (err_push),
    .pop_req    (pop_req),
    .pop_done   (pop_done),
    .pop_status (pop_status),
    .pop_type   (pop_type),
    .not_empty  (not_empty),
    .overflow   (overflow),
    .notify     (notify),
    .push_ok    (push_ok),
    .seq_state  (seq_state),
    .slot_fid   (slot_fid),
    .slot_fh    (slot_fh),
    .count      (fifo_count)
);

// File: tb/sim_bus_evt_queue.sv
module sim_bus_evt_queue;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         err_push = 1'b0;
    logic [31:0]  err_fid = '0, err_fh = '0, err_qual = '0;
    logic [63:0]  err_faddr = '0;
    logic [15:0]  err_code = '0;
    logic         plug_req = 1'b0, plug_live = 1'b0;
    logic [31:0]  plug_fid = '0, plug_fh = '0;
    logic         unplug_req = 1'b0, unplug_cfg = 1'b0;
    logic [31:0]  slot_fid, slot_fh;
    logic         seq_busy, pop_req = 1'b0, pop_done, pop_status;
    logic [1:0]   pop_type;
    logic [175:0] pop_rec;
    logic         not_empty, overflow, notify;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    bus_evt_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .err_push(err_push), .err_fid(err_fid), .err_fh(err_fh), .err_qual(err_qual),
        .err_faddr(err_faddr), .err_code(err_code),
        .plug_req(plug_req), .plug_live(plug_live), .plug_fid(plug_fid), .plug_fh(plug_fh),
        .unplug_req(unplug_req), .unplug_cfg(unplug_cfg),
        .slot_fid(slot_fid), .slot_fh(slot_fh), .seq_busy(seq_busy),
        .pop_req(pop_req), .pop_done(pop_done), .pop_status(pop_status),
        .pop_type(pop_type), .pop_rec(pop_rec),
        .not_empty(not_empty), .overflow(overflow), .notify(notify)
    );

    typedef struct packed {
        logic [31:0] fid;
        logic [31:0] fh;
        logic [31:0] qual;
        logic [63:0] faddr;
        logic [15:0] code;
    } vec_t;

    localparam vec_t VT [4] = '{
        '{32'h0000_0001, 32'h8000_0001, 32'h0000_0000, 64'h0000_0000_0000_1000, 16'h0009},
        '{32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_5A5A, 64'hFEDC_BA98_7654_3210, 16'hFFFF},
        '{32'h0000_001F, 32'h8000_001F, 32'h0000_0001, 64'h8000_0000_0000_0000, 16'h0002},
        '{32'h7FFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_F000, 16'h0100}
    };

    function automatic logic [175:0] exp_err(vec_t v);
        return {v.fid, v.fh, v.qual, v.faddr, v.code};
    endfunction

    function automatic logic [175:0] exp_avail(logic [31:0] fid, logic [31:0] fh, logic [15:0] code);
        return {fid, fh, code, 96'h0};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [175:0] act, logic [175:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_err(vec_t v, logic exp_notify);
        err_push = 1'b1; err_fid = v.fid; err_fh = v.fh; err_qual = v.qual;
        err_faddr = v.faddr; err_code = v.code;
        tick();
        err_push = 1'b0;
        chk("R5 notify after push", {175'd0, notify}, {175'd0, exp_notify});
    endtask

    task automatic pop_expect(string tag, logic exp_status, logic [1:0] exp_type, logic [175:0] exp_rec);
        pop_req = 1'b1;
        tick();
        pop_req = 1'b0;
        chk({tag, " pop_done"}, {175'd0, pop_done}, {175'd0, 1'b1});
        chk({tag, " status"},   {175'd0, pop_status}, {175'd0, exp_status});
        chk({tag, " type"},     {174'd0, pop_type}, {174'd0, exp_type});
        chk({tag, " record"},   pop_rec, exp_rec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        chk("R10 reset not_empty", {175'd0, not_empty}, 176'd0);
        chk("R8 reset overflow",   {175'd0, overflow}, 176'd0);
        chk("R5 reset notify",     {175'd0, notify}, 176'd0);
        chk("R7 reset slot",       {112'd0, slot_fid, slot_fh}, 176'd0);

        // R2: empty pop
        pop_expect("R2 empty pop", 1'b1, 2'd0, 176'd0);

        // table walk: R1 R3 error records in order
        for (int i = 0; i < 4; i++) push_err(VT[i], 1'b1);
        chk("R10 not_empty after pushes", {175'd0, not_empty}, {175'd0, 1'b1});
        for (int i = 0; i < 4; i++) pop_expect("R1 R3 error record", 1'b0, 2'd1, exp_err(VT[i]));
        chk("R10 empty after drain", {175'd0, not_empty}, 176'd0);

        // R6: live plug
        plug_req = 1'b1; plug_live = 1'b1; plug_fid = 32'h5; plug_fh = 32'h8000_0005;
        tick();
        plug_req = 1'b0;
        tick(); tick(); tick();
        chk("R6 slot latched", {112'd0, slot_fid, slot_fh}, {112'd0, 32'h5, 32'h8000_0005});
        pop_expect("R6 R4 rsv->stby", 1'b0, 2'd2, exp_avail(32'h5, 32'h8000_0005, 16'h0302));
        pop_expect("R6 R4 stby->cfg", 1'b0, 2'd2, exp_avail(32'h5, 32'h8000_0005, 16'h0301));
        pop_expect("R6 no third", 1'b1, 2'd0, 176'd0);

        // R6: plug while not live
        plug_req = 1'b1; plug_live = 1'b0; plug_fid = 32'h7; plug_fh = 32'h8000_0007;
        tick();
        plug_req = 1'b0;
        tick(); tick(); tick();
        chk("R6 quiet plug no events", {175'd0, not_empty}, 176'd0);
        chk("R6 quiet plug latched", {144'd0, slot_fid}, {144'd0, 32'h7});

        // R7: unplug configured
        unplug_req = 1'b1; unplug_cfg = 1'b1;
        tick();
        unplug_req = 1'b0;
        tick(); tick(); tick();
        chk("R7 slot cleared", {112'd0, slot_fid, slot_fh}, 176'd0);
        pop_expect("R7 cfg->stbyrsv", 1'b0, 2'd2, exp_avail(32'h7, 32'h8000_0007, 16'h0304));
        pop_expect("R7 stby->rsv",    1'b0, 2'd2, exp_avail(32'h7, 32'h8000_0007, 16'h0308));
        pop_expect("R7 no third",     1'b1, 2'd0, 176'd0);

        // R7: unplug not configured
        plug_req = 1'b1; plug_live = 1'b0; plug_fid = 32'h9; plug_fh = 32'h8000_0009;
        tick();
        plug_req = 1'b0;
        unplug_req = 1'b1; unplug_cfg = 1'b0;
        tick();
        unplug_req = 1'b0;
        tick(); tick();
        pop_expect("R7 only stby->rsv", 1'b0, 2'd2, exp_avail(32'h9, 32'h8000_0009, 16'h0308));
        pop_expect("R7 single event",   1'b1, 2'd0, 176'd0);
        chk("R7 slot cleared unconfigured", {112'd0, slot_fid, slot_fh}, 176'd0);

        // R9: error push collides with sequencer emission
        plug_req = 1'b1; plug_live = 1'b1; plug_fid = 32'h11; plug_fh = 32'h8000_0011;
        tick();
        plug_req = 1'b0;
        chk("R9 busy", {175'd0, seq_busy}, {175'd0, 1'b1});
        unplug_req = 1'b1; unplug_cfg = 1'b1;
        push_err(VT[1], 1'b1);
        unplug_req = 1'b0;
        tick(); tick(); tick();
        chk("R9 idle again", {175'd0, seq_busy}, 176'd0);
        chk("R9 unplug ignored", {144'd0, slot_fid}, {144'd0, 32'h11});
        pop_expect("R9 R1 error first", 1'b0, 2'd1, exp_err(VT[1]));
        pop_expect("R9 rsv->stby",      1'b0, 2'd2, exp_avail(32'h11, 32'h8000_0011, 16'h0302));
        pop_expect("R9 stby->cfg",      1'b0, 2'd2, exp_avail(32'h11, 32'h8000_0011, 16'h0301));
        pop_expect("R9 drained",        1'b1, 2'd0, 176'd0);

        // R8: overflow
        for (int i = 0; i < 16; i++) begin
            vec_t v;
            v = VT[0];
            v.fid = 32'(i + 100);
            push_err(v, 1'b1);
        end
        chk("R8 no overflow at 16", {175'd0, overflow}, 176'd0);
        begin
            vec_t v;
            v = VT[0];
            v.fid = 32'd999;
            push_err(v, 1'b0);
        end
        tick();
        chk("R8 overflow set", {175'd0, overflow}, {175'd0, 1'b1});
        for (int i = 0; i < 16; i++) begin
            vec_t v;
            v = VT[0];
            v.fid = 32'(i + 100);
            pop_expect("R8 R1 kept record", 1'b0, 2'd1, exp_err(v));
        end
        pop_expect("R8 dropped record absent", 1'b1, 2'd0, 176'd0);
        tick();
        chk("R8 overflow sticky", {175'd0, overflow}, {175'd0, 1'b1});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule